// File: doc/BRIEF.md
# Clocked Sequencer for an Asynchronous 256x4 Static RAM

This block sits between a synchronous request bus and one asynchronous static RAM of 256 four-bit words. The RAM has two chip selects (one active low, one active high), an output-disable pin and a read/write strobe. A client offers one-word reads or writes with a valid/ready handshake. The block then drives the RAM pins through a fixed, clock-counted sequence, so that each setup, pulse-width, recovery and access interval in the RAM's timing is met. Every interval is a nanosecond parameter. It is turned into a cycle count by rounding up against the clock-period parameter.

The sequence is a six-state machine. **IDLE** is the only state in which the block takes a request. **ADDR_SETUP** drives the address and selects the chip while the strobe is still high. **WR_PULSE** holds the strobe low. **RECOVER** raises the strobe again and holds address and data. **RD_WAIT** enables the RAM output and waits the access time. **CAPTURE** presents the read word with a one-cycle valid pulse.

The transitions are these:
- IDLE→ADDR_SETUP on an accepted write.
- IDLE→RD_WAIT on an accepted read.
- ADDR_SETUP→WR_PULSE, WR_PULSE→RECOVER, RECOVER→IDLE and RD_WAIT→CAPTURE, each when the state's cycle count runs out.
- CAPTURE→IDLE after one cycle.

A parameter selects shared-bus mode, in which output disable stays high through writes and the write data is driven only while the RAM output is off.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset the block shows `req_ready`=1 and `rd_valid`=0, with the RAM deselected (`mem_cs_n`=1, `mem_cs`=0), `mem_oe_off`=1, `mem_we_n`=1 and `mem_din_oe`=0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only in IDLE. While the block is busy, the request inputs have no effect on any RAM pin.
- R3: A write first spends SETUP_CYC cycles with the address and data driven, the chip selected and `mem_we_n`=1. SETUP_CYC is the larger of ceil(T_ADDR_SETUP_NS/CLK_NS) and ceil(T_OD_SETUP_NS/CLK_NS), which is 6 at the defaults.
- R4: The write pulse holds `mem_we_n`=0, with the chip selected, for exactly PULSE_CYC cycles. PULSE_CYC is the larger of the pulse-width and data-setup counts, which is 8 at the defaults.
- R5: After the pulse, RECOVER_CYC cycles follow with `mem_we_n`=1, the chip deselected and address and data unchanged. RECOVER_CYC is the larger of the recovery count and the write-cycle count minus SETUP_CYC and PULSE_CYC, which is 2 at the defaults. A write therefore keeps `req_ready` low for 16 cycles, which is at least ceil(300/20).
- R6: In shared-bus mode (`SHARED_IO`=1, the default), `mem_oe_off`=1 during every write state and `mem_din_oe`=1 only in write states. `mem_din_oe` is never 1 while the RAM output is enabled.
- R7: A read selects the chip with `mem_oe_off`=0 and `mem_we_n`=1 for ACCESS_CYC cycles. ACCESS_CYC is the larger of the access-time and read-cycle counts, which is 13 at the defaults. `mem_dout` is registered at the last edge of that window.
- R8: `rd_valid` is a single-cycle pulse in the cycle after the access window. `rd_data` holds the word stored at the requested address.
- R9: Cycle counts come from ns parameters rounded up. A read keeps `req_ready` low for ACCESS_CYC+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request (IDLE) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write word |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | DATA_W | Read result |
| mem_addr | output | ADDR_W | RAM address pins |
| mem_din | output | DATA_W | RAM data-in pins |
| mem_din_oe | output | 1 | Drive enable for data-in on a shared bus |
| mem_dout | input | DATA_W | RAM data-out pins |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_oe_off | output | 1 | Output disable, 1 = RAM output off |
| mem_we_n | output | 1 | Strobe, 0 = write |

## Verification
A state held one cycle too long or too short shows at the pins in the very cycle it happens. The strobe, select or output-disable level then disagrees with the bench's per-cycle model, and `req_ready` returns a cycle early or late. A short access window is caught through the bench's RAM model, which returns inverted data until the access time has passed, so `rd_data` is wrong at the next `rd_valid`. A lost or corrupted address or data register shows as a wrong read-back of a word written earlier, or as a pin mismatch during the write states.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_SETUP,
        ST_WR_PULSE,
        ST_RECOVER,
        ST_RD_WAIT,
        ST_CAPTURE
    } seq_state_e;

    // Registered pin controls, decoded from the state.
    typedef struct packed {
        logic ready;
        logic cs_n;
        logic cs;
        logic oe_off;
        logic we_n;
        logic din_oe;
        logic rd_valid;
    } pin_ctl_t;

    function automatic int ns_to_cyc(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_seq_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int SETUP_CYC  = 6,
    parameter int PULSE_CYC  = 8,
    parameter int RECOV_CYC  = 2,
    parameter int ACCESS_CYC = 13,
    parameter bit SHARED_IO  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture,
    output pin_ctl_t         ctl
);

    localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_PULSE  = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RECOV  = CNT_W'(RECOV_CYC - 1);
    localparam logic [CNT_W-1:0] LD_ACCESS = CNT_W'(ACCESS_CYC - 1);
    localparam logic             WR_OE_OFF = SHARED_IO ? 1'b1 : 1'b0;
    localparam logic             IDLE_DOE  = SHARED_IO ? 1'b0 : 1'b1;

    seq_state_e state_q, state_nx;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign capture = (state_q == ST_RD_WAIT) && tmr_done;

    // Next-state logic and timer reloads
    always_comb begin
        state_nx = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_nx = ST_ADDR_SETUP;
                        tmr_val  = LD_SETUP;
                    end else begin
                        state_nx = ST_RD_WAIT;
                        tmr_val  = LD_ACCESS;
                    end
                end
            end
            ST_ADDR_SETUP: begin
                if (tmr_done) begin
                    state_nx = ST_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_PULSE;
                end
            end
            ST_WR_PULSE: begin
                if (tmr_done) begin
                    state_nx = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RECOV;
                end
            end
            ST_RECOVER: begin
                if (tmr_done) state_nx = ST_IDLE;
            end
            ST_RD_WAIT: begin
                if (tmr_done) state_nx = ST_CAPTURE;
            end
            ST_CAPTURE: begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    function automatic pin_ctl_t decode(input seq_state_e s);
        pin_ctl_t c;
        c = '{ready: 1'b0, cs_n: 1'b1, cs: 1'b0, oe_off: 1'b1,
              we_n: 1'b1, din_oe: IDLE_DOE, rd_valid: 1'b0};
        unique case (s)
            ST_IDLE:       c.ready = 1'b1;
            ST_ADDR_SETUP: begin
                c.cs_n = 1'b0; c.cs = 1'b1; c.oe_off = WR_OE_OFF; c.din_oe = 1'b1;
            end
            ST_WR_PULSE:   begin
                c.cs_n = 1'b0; c.cs = 1'b1; c.oe_off = WR_OE_OFF; c.din_oe = 1'b1;
                c.we_n = 1'b0;
            end
            ST_RECOVER:    c.din_oe = 1'b1;
            ST_RD_WAIT:    begin
                c.cs_n = 1'b0; c.cs = 1'b1; c.oe_off = 1'b0;
            end
            ST_CAPTURE:    c.rd_valid = 1'b1;
            default:       c.ready = 1'b0;
        endcase
        return c;
    endfunction

    // Output register, decoded from the next state so pins line up with state_q
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl <= decode(ST_IDLE);
        else        ctl <= decode(state_nx);
    end

endmodule

// File: rtl/sram_seq_datapath.sv
module sram_seq_datapath #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dout,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_din,
    output logic [DATA_W-1:0] rd_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_din  <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            mem_din  <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_data <= '0;
        else if (capture) rd_data <= mem_dout;
    end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W           = 8,
    parameter int DATA_W           = 4,
    parameter int CLK_NS           = 20,
    parameter int T_ACCESS_NS      = 250,
    parameter int T_RD_CYCLE_NS    = 250,
    parameter int T_WR_CYCLE_NS    = 300,
    parameter int T_ADDR_SETUP_NS  = 110,
    parameter int T_OD_SETUP_NS    = 110,
    parameter int T_PULSE_NS       = 150,
    parameter int T_DATA_SETUP_NS  = 150,
    parameter int T_RECOVER_NS     = 40,
    parameter bit SHARED_IO        = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_din,
    output logic              mem_din_oe,
    input  logic [DATA_W-1:0] mem_dout,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_oe_off,
    output logic              mem_we_n
);

    localparam int SETUP_CYC = max_int(1, max_int(ns_to_cyc(T_ADDR_SETUP_NS, CLK_NS),
                                  SHARED_IO ? ns_to_cyc(T_OD_SETUP_NS, CLK_NS) : 0));
    localparam int PULSE_CYC = max_int(1, max_int(ns_to_cyc(T_PULSE_NS, CLK_NS),
                                                  ns_to_cyc(T_DATA_SETUP_NS, CLK_NS)));
    localparam int RECOV_CYC = max_int(1, max_int(ns_to_cyc(T_RECOVER_NS, CLK_NS),
                                  ns_to_cyc(T_WR_CYCLE_NS, CLK_NS) - SETUP_CYC - PULSE_CYC));
    localparam int ACCESS_CYC = max_int(1, max_int(ns_to_cyc(T_ACCESS_NS, CLK_NS),
                                                   ns_to_cyc(T_RD_CYCLE_NS, CLK_NS)));
    localparam int MAX_CYC = max_int(max_int(SETUP_CYC, PULSE_CYC),
                                     max_int(RECOV_CYC, ACCESS_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             tmr_load, tmr_done, accept, capture;
    logic [CNT_W-1:0] tmr_val;
    pin_ctl_t         ctl;

    sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_seq_fsm #(
        .CNT_W      (CNT_W),
        .SETUP_CYC  (SETUP_CYC),
        .PULSE_CYC  (PULSE_CYC),
        .RECOV_CYC  (RECOV_CYC),
        .ACCESS_CYC (ACCESS_CYC),
        .SHARED_IO  (SHARED_IO)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .tmr_done  (tmr_done),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .accept    (accept),
        .capture   (capture),
        .ctl       (ctl)
    );

    sram_seq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dout  (mem_dout),
        .mem_addr  (mem_addr),
        .mem_din   (mem_din),
        .rd_data   (rd_data)
    );

    assign req_ready  = ctl.ready;
    assign mem_cs_n   = ctl.cs_n;
    assign mem_cs     = ctl.cs;
    assign mem_oe_off = ctl.oe_off;
    assign mem_we_n   = ctl.we_n;
    assign mem_din_oe = ctl.din_oe;
    assign rd_valid   = ctl.rd_valid;

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 4,
    parameter int PULSE_CYC = 8,
    parameter bit SHARED_IO = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_din,
    input logic              mem_din_oe,
    input logic              mem_cs_n,
    input logic              mem_cs,
    input logic              mem_oe_off,
    input logic              mem_we_n
);

    logic [7:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         low_cnt <= '0;
        else if (!mem_we_n) low_cnt <= low_cnt + 1'b1;
        else                low_cnt <= '0;
    end

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && !mem_cs && mem_we_n && !rd_valid)); // R2

    AST_ACCEPT_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2

    AST_SETUP_BEFORE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(!mem_cs_n && mem_cs)); // R3

    AST_PULSE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_cs)); // R4

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (low_cnt == 8'(PULSE_CYC))); // R4

    AST_HOLD_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> ($stable(mem_addr) && $stable(mem_din))); // R5

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R8

    AST_VALID_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(!mem_oe_off && !mem_cs_n && mem_cs)); // R7

    generate
        if (SHARED_IO) begin : g_shared
            AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
                mem_din_oe |-> (mem_oe_off || mem_cs_n || !mem_cs)); // R6
            AST_OD_DURING_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                !mem_we_n |-> mem_oe_off); // R6
        end
    endgenerate

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PULSE_CYC (PULSE_CYC),
    .SHARED_IO (SHARED_IO)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .mem_addr   (mem_addr),
    .mem_din    (mem_din),
    .mem_din_oe (mem_din_oe),
    .mem_cs_n   (mem_cs_n),
    .mem_cs     (mem_cs),
    .mem_oe_off (mem_oe_off),
    .mem_we_n   (mem_we_n)
);

// File: tb/sram_seq_ctrl_bench.sv
module sram_seq_ctrl_bench;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    localparam int PER     = 20;
    localparam int B_SETUP = cdiv(110, PER);
    localparam int B_PULSE = cdiv(150, PER);
    localparam int B_RECOV = (cdiv(40, PER) > cdiv(300, PER) - B_SETUP - B_PULSE)
                             ? cdiv(40, PER) : cdiv(300, PER) - B_SETUP - B_PULSE;
    localparam int B_ACC   = cdiv(250, PER);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [7:0] req_addr = '0;
    logic [3:0] req_wdata = '0;
    logic       req_ready, rd_valid, mem_din_oe, mem_cs_n, mem_cs, mem_oe_off, mem_we_n;
    logic [3:0] rd_data, mem_din, mem_dout;
    logic [7:0] mem_addr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sram_seq_ctrl u_sram_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr), .mem_din(mem_din),
        .mem_din_oe(mem_din_oe), .mem_dout(mem_dout), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
        .mem_oe_off(mem_oe_off), .mem_we_n(mem_we_n)
    );

    // Behavioural RAM: output is wrong until the access time has elapsed
    logic [3:0] sram [256];
    int         acc_cnt;
    wire        sel    = !mem_cs_n && mem_cs;
    wire        rd_act = sel && !mem_oe_off && mem_we_n;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) sram[i] <= 4'(i) ^ 4'h9;
            acc_cnt <= 0;
        end else begin
            if (sel && !mem_we_n) sram[mem_addr] <= mem_din;
            acc_cnt <= rd_act ? acc_cnt + 1 : 0;
        end
    end
    assign mem_dout = (rd_act && acc_cnt >= B_ACC - 1) ? sram[mem_addr] : ~sram[mem_addr];

    // Cycle reference model: 0 idle, 1 setup, 2 pulse, 3 recover, 4 access, 5 result
    int         ph, left;
    logic [7:0] m_addr;
    logic [3:0] m_data;
    logic [3:0] ref_mem [256];

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; left = 0; m_addr = '0; m_data = '0;
            for (int i = 0; i < 256; i++) ref_mem[i] = 4'(i) ^ 4'h9;
        end else begin
            case (ph)
                0: if (req_valid) begin
                    m_addr = req_addr; m_data = req_wdata;
                    if (req_write) begin
                        ph = 1; left = B_SETUP; ref_mem[req_addr] = req_wdata;
                    end else begin
                        ph = 4; left = B_ACC;
                    end
                end
                1: if (left == 1) begin ph = 2; left = B_PULSE; end else left--;
                2: if (left == 1) begin ph = 3; left = B_RECOV; end else left--;
                3: if (left == 1) ph = 0; else left--;
                4: if (left == 1) ph = 5; else left--;
                default: ph = 0;
            endcase
        end
    end

    task automatic chk1(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h (phase %0d)", tag, what, act, exp, ph);
        end
    endtask

    // Compare every pin against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk1("R2", "req_ready", int'(req_ready), int'(ph == 0));
            chk1(ph == 2 ? "R4" : "R3", "mem_we_n", int'(mem_we_n), int'(ph != 2));
            chk1(ph == 3 ? "R5" : "R3", "chip select",
                 int'({mem_cs_n, mem_cs}), (ph == 1 || ph == 2 || ph == 4) ? 1 : 2);
            chk1(ph == 4 ? "R7" : "R6", "mem_oe_off", int'(mem_oe_off), int'(ph != 4));
            chk1("R6", "mem_din_oe", int'(mem_din_oe), int'(ph >= 1 && ph <= 3));
            chk1("R8", "rd_valid", int'(rd_valid), int'(ph == 5));
            if (ph != 0) chk1(ph == 3 ? "R5" : "R2", "mem_addr", int'(mem_addr), int'(m_addr));
            if (ph >= 1 && ph <= 3) chk1(ph == 3 ? "R5" : "R4", "mem_din", int'(mem_din), int'(m_data));
            if (ph == 5) chk1("R8", "rd_data", int'(rd_data), int'(ref_mem[m_addr]));
        end
    end

    task automatic send(input logic w, input logic [7:0] a, input logic [3:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = ~w; req_addr = ~a; req_wdata = ~d;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    // Busy length: cycles with ready low after one accepted request
    task automatic busy_len(input logic w, input logic [7:0] a, input logic [3:0] d,
                            output int n);
        wait_idle();
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!req_ready) begin n++; @(negedge clk); end
    endtask

    int pulses = 0;
    always @(negedge clk) if (rst_n && rd_valid) pulses++;

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk1("R1", "req_ready", int'(req_ready), 1);
        chk1("R1", "rd_valid", int'(rd_valid), 0);
        chk1("R1", "select", int'({mem_cs_n, mem_cs}), 2);
        chk1("R1", "oe_off/we_n/din_oe", int'({mem_oe_off, mem_we_n, mem_din_oe}), 6);
        rst_n = 1'b1;

        send(1'b1, 8'h00, 4'hA);
        send(1'b1, 8'hFF, 4'h5);
        send(1'b1, 8'h3C, 4'h0);
        send(1'b0, 8'h00, 4'h0);
        send(1'b0, 8'hFF, 4'h0);
        send(1'b0, 8'h3C, 4'h0);
        send(1'b0, 8'h81, 4'h0);   // never written

        // R9: occupancy in cycles
        busy_len(1'b1, 8'h42, 4'h7, n);
        chk1("R9", "write busy cycles", n, B_SETUP + B_PULSE + B_RECOV);
        chk1("R5", "write busy >= write cycle", int'(n >= cdiv(300, PER)), 1);
        busy_len(1'b0, 8'h42, 4'h0, n);
        chk1("R9", "read busy cycles", n, B_ACC + 1);

        // R2: a request held through a busy period is taken only at idle
        wait_idle();
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h10; req_wdata = 4'hC;
        @(negedge clk);
        req_write = 1'b0; req_addr = 8'h10;
        repeat (B_SETUP + B_PULSE + B_RECOV + 2) @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);
        chk1("R8", "rd_valid pulse count", pulses, 6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule